// File: doc/BRIEF.md
# Switched-Section Integral Voltage Regulator

This block holds the output of a high-voltage cell array near an operator-chosen level by deciding which of eight binary-weighted cell sections are placed in series with a fixed base section. The 8-bit switch word is the only state of the control loop. Bit i of the word controls the section whose weight is 2^i least-significant steps. One step is roughly 1/256 of the switchable span.

In each iteration, the block accepts one 8-bit voltage sample. This sample is the upper byte of a 12-bit conversion. The block subtracts the sample from the loaded reference to form a signed error. It then scales the error down by a programmable right shift, which acts as the loop gain. The scaled error is added to the present switch word, and the result is clamped to the range 0..255 rather than allowed to wrap. After each update the block waits a programmable number of clock cycles so that the array can settle, and only then does it accept the next sample.

A system integrator connects the converter's data and valid strobe to the sample inputs and routes the switch word to the section shorting switches. The reference and the settle delay are loaded at run time. Lowering the enable input freezes the word and cancels any settle wait that is in progress.

Top module: `volt_step_regulator`

## Requirements
- R1: After reset, the switch word is 0 and iteration_done is 0. The stored reference and the stored settle delay are both 0.
- R2: A high ref_load or delay_load at a clock edge stores ref_in or delay_in. The new value is first used by the next sample accepted after that edge.
- R3: The error is reference minus sample, formed as a signed 9-bit value. The step is the error shifted right arithmetically by gain_shift (0..7), so negative results round toward minus infinity (error −1 gives step −1 at any shift).
- R4: An accepted sample sets the switch word to the sum of the old word and the step, clamped to 0 when the sum is negative and to 255 when it exceeds 255. Bit i of switch_word equal to 1 means section i (weight 2^i) contributes, and 0 means the section is shorted.
- R5: iteration_done is high for exactly one cycle, in the first cycle in which the updated word is visible. The switch word changes in no other cycle.
- R6: A sample is accepted at an edge where enable and sample_valid are high and no settle wait is running. An accepted sample starts a wait of D+1 edges, where D is the stored delay, during which samples are ignored. With a continuously valid sample, iteration_done pulses therefore occur every D+2 cycles.
- R7: While enable is low, the switch word holds, samples are ignored and any settle wait is cleared. The first valid sample after enable rises is accepted at once.
- R8: A step of zero leaves the word unchanged but still pulses iteration_done and starts a settle wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Loop enable |
| ref_load | input | 1 | Store ref_in as the reference |
| ref_in | input | 8 | Reference level in sample units |
| delay_load | input | 1 | Store delay_in as the settle delay |
| delay_in | input | 16 | Settle delay in clock cycles |
| gain_shift | input | 3 | Right shift applied to the error |
| sample_valid | input | 1 | Sample strobe from the converter |
| sample | input | 8 | Sensed output voltage, upper byte |
| switch_word | output | 8 | Section switch pattern |
| iteration_done | output | 1 | One-cycle pulse after each update |

## Verification
The checker watches four properties on every cycle. The word stays frozen while the loop is disabled, and it moves only in a cycle marked by iteration_done. No two update pulses are adjacent. Each update moves the word in the direction that the sign of the error requires. The exact step size, the floor rounding of negative shifted errors, the clamping at both ends, the D+2 spacing of updates and the immediate acceptance after re-enable can only be shown by the bench's scenarios, which compare against a behavioural model on every clock.

// File: rtl/vsr_pkg.sv
// Shared types for the switched-section regulator.
package vsr_pkg;
    // Loop phase: waiting for a sample, or waiting for the array to settle.
    typedef enum logic {
        PH_ACQ    = 1'b0,
        PH_SETTLE = 1'b1
    } vsr_phase_t;
endpackage

// File: rtl/vsr_step.sv
// Error and gain stage.
// Forms the signed error (reference - sample) and scales it by an
// arithmetic right shift. Purely combinational.
// Assumes both operands are unsigned and of the same width.
module vsr_step #(
    parameter int SAMPLE_W = 8,
    parameter int SHIFT_W  = 3
) (
    input  logic [SAMPLE_W-1:0]      ref_val,
    input  logic [SAMPLE_W-1:0]      sample_val,
    input  logic [SHIFT_W-1:0]       shift,
    output logic signed [SAMPLE_W:0] step
);
    localparam int ERR_W = SAMPLE_W + 1;

    logic signed [ERR_W-1:0] err;

    // Signed difference, then floor-rounded gain by arithmetic shift.
    always_comb begin
        err  = $signed({1'b0, ref_val}) - $signed({1'b0, sample_val});
        step = err >>> shift;
    end
endmodule

// File: rtl/vsr_accum.sv
// Saturating integrator whose state is the switch word itself.
// On take, the word becomes clamp(word + step, 0, 2^WORD_W-1). It also
// registers a one-cycle done pulse that is aligned with the new word.
// Assumes the step is a signed value that is at most WORD_W+1 bits wide.
module vsr_accum #(
    parameter int WORD_W = 8,
    parameter int STEP_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     take,
    input  logic signed [STEP_W-1:0] step,
    output logic [WORD_W-1:0]        word_q,
    output logic                     done_q
);
    localparam int BASE_W = (WORD_W > STEP_W) ? WORD_W : STEP_W;
    localparam int SUM_W  = BASE_W + 2;
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << WORD_W) - 1);

    logic signed [SUM_W-1:0] sum;
    logic [WORD_W-1:0]       next_word;

    // Widen both operands, add them, and clamp the result to the word range.
    always_comb begin
        sum = $signed({{(SUM_W-WORD_W){1'b0}}, word_q})
            + $signed({{(SUM_W-STEP_W){step[STEP_W-1]}}, step});
        if (sum[SUM_W-1])
            next_word = '0;
        else if (sum > MAXV)
            next_word = '1;
        else
            next_word = sum[WORD_W-1:0];
    end

    // Word register and its done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= take;
            if (take)
                word_q <= next_word;
        end
    end
endmodule

// File: rtl/vsr_settle.sv
// Settle timer and acceptance gate.
// After each accepted sample, ignores samples for delay_val+1 edges.
// Disabling the loop returns it to the acquire phase at once.
// Assumes delay_val is stable whenever a sample is accepted.
module vsr_settle #(
    parameter int DELAY_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               sample_valid,
    input  logic [DELAY_W-1:0] delay_val,
    output logic               accept
);
    import vsr_pkg::*;

    vsr_phase_t         phase;
    logic [DELAY_W-1:0] cnt;

    // A sample counts only when enabled and no wait is running.
    assign accept = enable && sample_valid && (phase == PH_ACQ);

    // Phase and countdown sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase <= PH_ACQ;
            cnt   <= '0;
        end else if (accept) begin
            phase <= PH_SETTLE;
            cnt   <= delay_val;
        end else if (phase == PH_SETTLE) begin
            if (cnt == '0)
                phase <= PH_ACQ;
            else
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/volt_step_regulator.sv
// Top level of the switched-section integral voltage regulator.
// Holds the reference and settle-delay registers and connects the
// error/gain stage, the saturating integrator and the settle timer.
// Assumes one sample per sample_valid strobe, in sample units.
module volt_step_regulator #(
    parameter int SAMPLE_W = 8,
    parameter int WORD_W   = 8,
    parameter int SHIFT_W  = 3,
    parameter int DELAY_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                ref_load,
    input  logic [SAMPLE_W-1:0] ref_in,
    input  logic                delay_load,
    input  logic [DELAY_W-1:0]  delay_in,
    input  logic [SHIFT_W-1:0]  gain_shift,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [WORD_W-1:0]   switch_word,
    output logic                iteration_done
);
    localparam int STEP_W = SAMPLE_W + 1;

    logic [SAMPLE_W-1:0]      ref_q;
    logic [DELAY_W-1:0]       delay_q;
    logic signed [STEP_W-1:0] step;
    logic                     accept;

    // Operator-loaded reference and settle-delay registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= '0;
            delay_q <= '0;
        end else begin
            if (ref_load)
                ref_q <= ref_in;
            if (delay_load)
                delay_q <= delay_in;
        end
    end

    vsr_step #(.SAMPLE_W(SAMPLE_W), .SHIFT_W(SHIFT_W)) u_step (
        .ref_val    (ref_q),
        .sample_val (sample),
        .shift      (gain_shift),
        .step       (step)
    );

    vsr_settle #(.DELAY_W(DELAY_W)) u_settle (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .sample_valid (sample_valid),
        .delay_val    (delay_q),
        .accept       (accept)
    );

    vsr_accum #(.WORD_W(WORD_W), .STEP_W(STEP_W)) u_accum (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (accept),
        .step   (step),
        .word_q (switch_word),
        .done_q (iteration_done)
    );
endmodule

// File: rtl/vsr_chk.sv
// Property checker for volt_step_regulator, attached by bind.
module vsr_chk #(
    parameter int SAMPLE_W = 8,
    parameter int WORD_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic                sample_valid,
    input logic [SAMPLE_W-1:0] sample,
    input logic [SAMPLE_W-1:0] ref_q,
    input logic [WORD_W-1:0]   switch_word,
    input logic                iteration_done
);
    // R7
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(switch_word));

    // R5
    word_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !iteration_done |-> $stable(switch_word));

    // R5
    done_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iteration_done |-> $past(enable && sample_valid));

    // R6
    done_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iteration_done |=> !iteration_done);

    // R4
    rise_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iteration_done && $past(sample <= ref_q)) |-> (switch_word >= $past(switch_word)));

    // R4
    fall_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iteration_done && $past(sample >= ref_q)) |-> (switch_word <= $past(switch_word)));
endmodule

bind volt_step_regulator vsr_chk #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (enable),
    .sample_valid   (sample_valid),
    .sample         (sample),
    .ref_q          (ref_q),
    .switch_word    (switch_word),
    .iteration_done (iteration_done)
);

// File: tb/sim_volt_step_regulator.sv
module sim_volt_step_regulator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        ref_load = 1'b0;
    logic [7:0]  ref_in = '0;
    logic        delay_load = 1'b0;
    logic [15:0] delay_in = '0;
    logic [2:0]  gain_shift = '0;
    logic        sample_valid = 1'b0;
    logic [7:0]  sample = '0;
    logic [7:0]  switch_word;
    logic        iteration_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    volt_step_regulator u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .ref_load(ref_load), .ref_in(ref_in),
        .delay_load(delay_load), .delay_in(delay_in),
        .gain_shift(gain_shift), .sample_valid(sample_valid),
        .sample(sample), .switch_word(switch_word),
        .iteration_done(iteration_done)
    );

    // Behavioural reference model, updated on each rising edge.
    int m_word, m_ref, m_delay, m_cnt;
    bit m_busy, m_done;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_word = 0; m_ref = 0; m_delay = 0; m_cnt = 0;
            m_busy = 0; m_done = 0;
        end else begin
            if (enable && sample_valid && !m_busy) begin
                int e, st;
                e  = m_ref - int'(sample);
                st = e >>> gain_shift;
                m_word = m_word + st;
                if (m_word < 0) m_word = 0;
                if (m_word > 255) m_word = 255;
                m_done = 1; m_busy = 1; m_cnt = m_delay;
            end else begin
                m_done = 0;
                if (!enable) begin
                    m_busy = 0; m_cnt = 0;
                end else if (m_busy) begin
                    if (m_cnt == 0) m_busy = 0;
                    else m_cnt = m_cnt - 1;
                end
            end
            if (ref_load) m_ref = int'(ref_in);
            if (delay_load) m_delay = int'(delay_in);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(int'(switch_word) == m_word, "R4 model word", int'(switch_word), m_word);
            check(iteration_done == m_done, "R5 model done", int'(iteration_done), int'(m_done));
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Wait for a done pulse; returns the number of cycles waited.
    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!iteration_done && n < 1000);
    endtask

    task automatic load(input int r, input int d);
        ref_in = 8'(r); delay_in = 16'(d); ref_load = 1; delay_load = 1;
        cyc(1);
        ref_load = 0; delay_load = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        check(switch_word == 0, "R1 word", int'(switch_word), 0);
        check(iteration_done == 0, "R1 done", int'(iteration_done), 0);

        // R1: stored reference is 0, so sample 0 gives zero error.
        enable = 1; sample = 0; sample_valid = 1;
        wait_done(n);
        check(switch_word == 0, "R1 ref zero", int'(switch_word), 0);
        enable = 0; sample_valid = 0; cyc(1);

        // R2 load reference 200, delay 3; R4 accumulate up to the clamp.
        load(200, 3);
        gain_shift = 0; sample = 100; sample_valid = 1; enable = 1;
        wait_done(n);
        check(switch_word == 100, "R4 first step", int'(switch_word), 100);
        cyc(1);
        check(iteration_done == 0, "R5 single pulse", int'(iteration_done), 0);
        wait_done(n);
        // R6: updates with a continuous valid sample are spaced D+2 cycles apart.
        check(n == 4, "R6 spacing d3", n, 4);
        check(switch_word == 200, "R4 second step", int'(switch_word), 200);
        wait_done(n);
        check(switch_word == 255, "R4 clamp high", int'(switch_word), 255);

        // R4 clamp low with a large negative error.
        enable = 0; cyc(1);
        load(10, 0);
        sample = 250; enable = 1;
        wait_done(n);
        check(switch_word == 15, "R4 down step", int'(switch_word), 15);
        wait_done(n);
        check(n == 2, "R6 spacing d0", n, 2);
        check(switch_word == 0, "R4 clamp low", int'(switch_word), 0);

        // R3 floor rounding: error -1 at shift 3 gives step -1.
        enable = 0; cyc(1);
        load(140, 1);
        gain_shift = 0; sample = 40; enable = 1;
        wait_done(n);
        check(switch_word == 100, "R3 setup", int'(switch_word), 100);
        gain_shift = 3; sample = 141;
        wait_done(n);
        check(switch_word == 99, "R3 floor neg", int'(switch_word), 99);
        // R8: error +2 at shift 3 gives step 0, but a pulse still occurs.
        sample = 138;
        wait_done(n);
        check(switch_word == 99, "R8 zero step", int'(switch_word), 99);
        check(n == 3, "R8 settle restarted", n, 3);
        // R3 positive shift: error 40 at shift 2 gives step 10.
        gain_shift = 2; sample = 100;
        wait_done(n);
        check(switch_word == 109, "R3 shift pos", int'(switch_word), 109);

        // R7: disable during a long settle wait; word holds and samples are ignored.
        enable = 0; cyc(1);
        load(140, 50);
        gain_shift = 0; sample = 0; enable = 1;
        wait_done(n);
        check(switch_word == 249, "R7 setup", int'(switch_word), 249);
        cyc(3);
        enable = 0; sample = 255;
        cyc(6);
        check(switch_word == 249, "R7 hold", int'(switch_word), 249);
        check(iteration_done == 0, "R7 no pulse", int'(iteration_done), 0);
        enable = 1;
        cyc(1);
        check(iteration_done == 1, "R7 immediate accept", int'(iteration_done), 1);
        check(switch_word == 134, "R7 after enable", int'(switch_word), 134);

        // R2: a reference loaded during a wait applies to the next accepted sample.
        enable = 0; cyc(1);
        load(140, 4);
        sample = 134; enable = 1;
        wait_done(n);
        check(switch_word == 140, "R2 pre", int'(switch_word), 140);
        ref_in = 150; ref_load = 1; cyc(1); ref_load = 0;
        wait_done(n);
        check(switch_word == 156, "R2 new ref", int'(switch_word), 156);
        // R6: samples are ignored while the wait runs.
        sample_valid = 0; cyc(10);
        check(switch_word == 156, "R6 no valid no move", int'(switch_word), 156);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule